// File: doc/BRIEF.md
# Transmit-only serial memory streamer

This block holds a 128-byte array and sends it, one bit per pulse of a dedicated output clock, on an open-drain serial data line. No command or address is ever sent to it. After reset it goes through an initialization phase of nine output-clock pulses. The level seen on the data line during that phase picks where streaming begins. From then on it sends whole words with no gaps: eight data bits, then a released slot. After the top address it wraps back to the bottom of the array.

A second clock input, the mode clock, is idle high while the block streams. Its first falling edge hands the line over to a bidirectional two-wire mode, which is handled outside this block. From that point the streamer stays silent until reset. All three external inputs are brought into the system clock domain through two-flop synchronizers, and every edge is detected from the synchronized values. A write port loads the array.

Top module: `ddc_tx_streamer`

## Requirements
- R1: After reset the mode flag is low and the line is released (`sda_oe`=0). The line stays released through the first nine output-clock rising edges, which make up initialization.
- R2: If the data line reads high at the eighth initialization rising edge, streaming starts at address 0x7F.
- R3: If the data line reads low at the eighth initialization rising edge, streaming starts at address 0x00.
- R4: A word is nine bit slots. The first eight carry the byte most significant bit first, and the ninth leaves the line released. Words follow one another with no idle slot.
- R5: The address goes up by one per word, and address 0x00 follows 0x7F.
- R6: A falling edge on the mode clock sets `bidir_mode`, releases the line and stops streaming. Further output-clock and mode-clock activity changes nothing until reset.
- R7: The line is open-drain. A 0 bit is sent as `sda_oe`=1 (pull low), and a 1 bit or a released slot as `sda_oe`=0.
- R8: `sda_oe` changes only after a synchronized output-clock rising edge or mode-clock falling edge. Between such edges it holds steady, ready for a receiver sampling on the next rising edge.
- R9: When `wr_en` is high, `wr_data` is written to array location `wr_addr` on a system clock edge. Later streaming of that address sends the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oclk | input | 1 | Output clock, one bit slot per rising edge |
| mclk | input | 1 | Mode clock, idle high; a falling edge selects bidirectional mode |
| sda_in | input | 1 | Sensed level of the serial data line |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | 7 | Array write address |
| wr_data | input | 8 | Array write data |
| bidir_mode | output | 1 | Sticky flag, set once the block has yielded to bidirectional mode |

## Verification
The hardest case to reach is a mode switch in the middle of a word, at a moment when the line is pulled low. The bench sets this up by loading a byte with zero bits at the start address and stepping the output clock until a 0 bit is on the line, then dropping the mode clock. A scoreboard holds the expected pull-down state for every slot, built from a bench copy of the array. It then checks that the line is released and stays released through further pulses and another mode-clock edge.

// File: rtl/ddc_tx_streamer.sv
module ddc_tx_streamer #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int INIT_PULSES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oclk,
  input  logic          mclk,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          bidir_mode
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = DW + 1;
  localparam int MAXC  = (INIT_PULSES > SLOTS) ? INIT_PULSES : SLOTS;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);
  localparam logic [CW-1:0] LAST_BIT  = CW'(SLOTS - 2);
  localparam logic [CW-1:0] SEL_PULSE = CW'(INIT_PULSES - 2);
  localparam logic [CW-1:0] END_PULSE = CW'(INIT_PULSES - 1);

  logic [DW-1:0] mem [DEPTH];

  logic oclk_m, oclk_s, oclk_d;
  logic mclk_m, mclk_s, mclk_d;
  logic sda_m, sda_s;

  logic          streaming, bidir, sel_hi;
  logic [CW-1:0] icnt, pos;
  logic [AW-1:0] addr;
  logic [DW-1:0] word;

  wire orise = oclk_s & ~oclk_d;
  wire mfall = mclk_d & ~mclk_s;
  wire [AW-1:0] start    = sel_hi ? {AW{1'b1}} : {AW{1'b0}};
  wire [AW-1:0] nxt_addr = addr + 1'b1;
  wire [DW-1:0] shifted  = word << pos;
  wire          step     = orise & ~bidir & ~mfall;

  assign sda_oe     = streaming & ~bidir & (pos != LAST_SLOT) & ~shifted[DW-1];
  assign bidir_mode = bidir;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {oclk_m, oclk_s, oclk_d} <= 3'b000;
      {mclk_m, mclk_s, mclk_d} <= 3'b111;
      {sda_m, sda_s}           <= 2'b11;
    end else begin
      {oclk_m, oclk_s, oclk_d} <= {oclk, oclk_m, oclk_s};
      {mclk_m, mclk_s, mclk_d} <= {mclk, mclk_m, mclk_s};
      {sda_m, sda_s}           <= {sda_in, sda_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streaming <= 1'b0;
      bidir     <= 1'b0;
      sel_hi    <= 1'b0;
      icnt      <= '0;
      pos       <= '0;
      addr      <= '0;
      word      <= '0;
    end else begin
      if (mfall) bidir <= 1'b1;
      if (step) begin
        if (!streaming) begin
          icnt <= icnt + 1'b1;
          if (icnt == SEL_PULSE) sel_hi <= sda_s;
          if (icnt == END_PULSE) begin
            streaming <= 1'b1;
            addr      <= start;
            word      <= mem[start];
            pos       <= '0;
          end
        end else if (pos == LAST_SLOT) begin
          pos <= '0;
        end else begin
          pos <= pos + 1'b1;
          if (pos == LAST_BIT) begin
            addr <= nxt_addr;
            word <= mem[nxt_addr];
          end
        end
      end
    end
  end

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && streaming && pos == LAST_BIT && addr == {AW{1'b1}}) |=> addr == '0);
  p_word_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && streaming && pos == LAST_SLOT) |=> (pos == '0 && streaming));
  p_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mfall |=> (bidir_mode && !sda_oe));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> bidir_mode);
  p_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!orise && !mfall) |=> $stable(sda_oe));
endmodule

// File: tb/ddc_tx_streamer_bench.sv
module ddc_tx_streamer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oclk = 1'b0, mclk = 1'b1, sda_in = 1'b1;
  logic wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sda_oe, bidir_mode;

  int checks = 0, errors = 0;
  logic [7:0] model [128];
  bit   exp_q [$];
  string tag_q [$];
  event smp_ev;
  int pos, addr;

  always #10 clk = ~clk;

  ddc_tx_streamer u_ddc_tx_streamer (
    .clk(clk), .rst_n(rst_n), .oclk(oclk), .mclk(mclk), .sda_in(sda_in),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bidir_mode(bidir_mode)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  always begin
    @(smp_ev);
    while (exp_q.size() > 0) check(tag_q.pop_front(), sda_oe, exp_q.pop_front());
  end

  task automatic write_mem(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic pulse();
    oclk = 1'b1;
    repeat (6) @(posedge clk);
    oclk = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input bit e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    ->smp_ev;
    #1;
  endtask

  function automatic bit slot_exp();
    if (pos == 8) return 1'b0;
    return ~model[addr][7-pos];
  endfunction

  task automatic do_init(input logic level);
    sda_in = level;
    for (int k = 1; k <= 9; k++) begin
      pulse();
      if (k < 9) push(1'b0, "R1 init released");
    end
    addr = level ? 127 : 0;
    pos = 0;
    push(slot_exp(), level ? "R2 start 7F" : "R3 start 00");
  endtask

  task automatic stream(input int n, input string t);
    for (int k = 0; k < n; k++) begin
      pulse();
      if (pos == 8) begin pos = 0; addr = (addr + 1) % 128; end
      else pos++;
      push(slot_exp(), t);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; oclk = 1'b0; mclk = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic held;
    for (int i = 0; i < 128; i++) write_mem(i, 8'((i * 29 + 7) ^ 8'h3C));
    write_mem(127, 8'h96);
    write_mem(0, 8'h3A);
    do_reset();
    check("R1 reset oe", sda_oe, 1'b0);
    check("R1 reset mode", bidir_mode, 1'b0);
    do_init(1'b1);
    stream(8, "R4 R7 first word");
    stream(9, "R5 wrap to 00");
    stream(9, "R5 next word");
    held = sda_oe;
    repeat (20) @(negedge clk);
    check("R8 steady between edges", sda_oe, held);

    do_reset();
    write_mem(0, 8'hA5);
    write_mem(1, 8'h0F);
    do_init(1'b0);
    stream(8, "R9 rewritten byte");
    stream(9, "R4 second word");
    while (!(pos < 8 && model[addr][7-pos] == 1'b0)) stream(1, "R4 seek zero");
    check("R7 pulls low on 0", sda_oe, 1'b1);
    mclk = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 mode flag", bidir_mode, 1'b1);
    check("R6 line released", sda_oe, 1'b0);
    for (int k = 0; k < 10; k++) begin
      pulse();
      check("R6 silent after switch", sda_oe, 1'b0);
    end
    mclk = 1'b1; repeat (8) @(negedge clk);
    mclk = 1'b0; repeat (8) @(negedge clk);
    check("R6 still bidir", bidir_mode, 1'b1);
    check("R6 still released", sda_oe, 1'b0);
    do_reset();
    check("R1 reset clears mode", bidir_mode, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule